// File: doc/BRIEF.md
# Idle Mode Power Controller

This controller parks a CPU core in a low-power idle state and brings it back. A power-save request from the core starts the entry sequence. For one entry cycle the controller withholds the CPU clock enable and pulses a watchdog clear. It then rests in idle with the CPU clock still withheld. The system clock and every peripheral clock keep running throughout, because this block only gates the core's enable.

Three events end idle:
- an interrupt line whose pending bit and enable bit are both set;
- a watchdog timeout;
- the asynchronous reset.

After an interrupt or watchdog wake, the CPU clock enable returns at once. A single-cycle resume strobe marks the cycle in which execution restarts, a fixed number of cycles after the wake event. A vector-select flag tells the core where to resume:
- at the interrupt handler, if an interrupt caused the wake;
- at the instruction after the power-save command, if the watchdog caused it.

An enabled interrupt that arrives together with the power-save request, or during the entry cycle, does not abort the entry. It is held, and it wakes the core as soon as entry completes.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low, and from the moment it falls without waiting for a clock edge, `cpu_clk_en_o`=1, `wdt_clr_o`=0, `resume_o`=0 and `vec_sel_o`=0. The controller restarts in the run state.
- R2: A `pwrsav_req_i` sampled high in the run state drops `cpu_clk_en_o` in the next cycle (the entry cycle). It stays low until a wake event.
- R3: `wdt_clr_o` is high for exactly one cycle per idle entry: the entry cycle. It is low at all other times.
- R4: In idle, any bit position where both `irq_pend_i` and `irq_en_i` are 1 wakes the core. A pending bit whose enable bit is 0 does not wake it.
- R5: In idle, `wdt_timeout_i`=1 wakes the core.
- R6: The cycle after the wake-event cycle has `cpu_clk_en_o`=1. `resume_o` is a one-cycle pulse exactly WAKE_LAT cycles after the wake-event cycle. WAKE_LAT is a parameter from 2 to 4, default 3. `cpu_clk_en_o` stays 1 after the pulse.
- R7: `vec_sel_o` is 1 when an interrupt caused the wake and 0 when the watchdog did. Interrupt wins if both occur in the same cycle. The value appears in the cycle after the wake event and holds until the next wake or reset.
- R8: An enabled interrupt seen together with an accepted `pwrsav_req_i`, or during the entry cycle, still lets the entry cycle complete, including the watchdog clear. The entry cycle is then the wake-event cycle, and `vec_sel_o`=1.
- R9: `pwrsav_req_i` has no effect outside the run state. It causes no second watchdog clear and no extra entry.
- R10: In the run state, `wdt_timeout_i` and interrupts have no effect: `cpu_clk_en_o` stays 1, and `wdt_clr_o` and `resume_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, never gated by this block |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrsav_req_i | input | 1 | Power-save command from the core |
| irq_pend_i | input | NUM_IRQ | Interrupt pending flags |
| irq_en_i | input | NUM_IRQ | Per-line interrupt enables |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| wdt_clr_o | output | 1 | Watchdog counter clear pulse |
| resume_o | output | 1 | Execution restart strobe |
| vec_sel_o | output | 1 | 1: resume at the interrupt handler, 0: resume at the next instruction |

## Verification
A wrong internal state appears at the ports within a cycle or two. A state stuck in idle holds `cpu_clk_en_o` low after a valid wake. A lost held interrupt leaves the core idle after the entry cycle instead of waking. A miscounting latency timer moves `resume_o` off the WAKE_LAT-th cycle, or makes it last more than one cycle. A wrong wake-source record flips `vec_sel_o` in the cycle after the wake. Every case is therefore judged by cycle-exact sampling of the four outputs around entry and wake.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_IDLE  = 2'd2,
    ST_WAKE  = 2'd3
  } idle_state_e;
endpackage

// File: rtl/idle_irq_mask.sv
module idle_irq_mask #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic               any_o
);
  logic [NUM_IRQ-1:0] live;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign live[g] = pend_i[g] & en_i[g];
  end

  assign any_o = |live;
endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer #(
  parameter int WAKE_LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = (WAKE_LAT > 2) ? $clog2(WAKE_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_LAT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAST) act_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == LAST);
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_pwr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwrsav_req_i,
  input  logic        irq_any_i,
  input  logic        wdt_timeout_i,
  input  logic        lat_done_i,
  output logic        lat_start_o,
  output idle_state_e state_o,
  output logic        vec_sel_o
);
  idle_state_e state_q, state_d;
  logic        hold_q, hold_d;
  logic        vec_q, vec_d;

  always_comb begin
    state_d     = state_q;
    hold_d      = hold_q;
    vec_d       = vec_q;
    lat_start_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pwrsav_req_i) begin
          state_d = ST_ENTER;
          hold_d  = irq_any_i;  // coincident interrupt held until entry completes
        end
      end
      ST_ENTER: begin
        hold_d = 1'b0;
        if (hold_q || irq_any_i) begin
          state_d     = ST_WAKE;
          vec_d       = 1'b1;
          lat_start_o = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (irq_any_i) begin
          state_d     = ST_WAKE;
          vec_d       = 1'b1;
          lat_start_o = 1'b1;
        end else if (wdt_timeout_i) begin
          state_d     = ST_WAKE;
          vec_d       = 1'b0;
          lat_start_o = 1'b1;
        end
      end
      ST_WAKE: begin
        if (lat_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      hold_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      vec_q   <= vec_d;
    end
  end

  assign state_o   = state_q;
  assign vec_sel_o = vec_q;
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pwr_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int WAKE_LAT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrsav_req_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wdt_timeout_i,
  output logic               cpu_clk_en_o,
  output logic               wdt_clr_o,
  output logic               resume_o,
  output logic               vec_sel_o
);
  if (WAKE_LAT < 2 || WAKE_LAT > 4) begin : g_bad_lat
    $error("WAKE_LAT must lie in 2..4");
  end

  logic        irq_any;
  logic        lat_start;
  logic        lat_done;
  idle_state_e state;

  idle_irq_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .pend_i (irq_pend_i),
    .en_i   (irq_en_i),
    .any_o  (irq_any)
  );

  idle_wake_timer #(.WAKE_LAT(WAKE_LAT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lat_start),
    .done_o  (lat_done)
  );

  idle_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwrsav_req_i  (pwrsav_req_i),
    .irq_any_i     (irq_any),
    .wdt_timeout_i (wdt_timeout_i),
    .lat_done_i    (lat_done),
    .lat_start_o   (lat_start),
    .state_o       (state),
    .vec_sel_o     (vec_sel_o)
  );

  assign cpu_clk_en_o = (state == ST_RUN) || (state == ST_WAKE);
  assign wdt_clr_o    = (state == ST_ENTER);
  assign resume_o     = (state == ST_WAKE) && lat_done;
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk
  import idle_pwr_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int WAKE_LAT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwrsav_req_i,
  input logic [NUM_IRQ-1:0] irq_pend_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic               wdt_timeout_i,
  input logic               cpu_clk_en_o,
  input logic               wdt_clr_o,
  input logic               resume_o,
  input logic               vec_sel_o,
  input idle_state_e        state_i
);
  logic       irq_any;
  logic       en_prev_q;
  logic [3:0] cnt_q;
  logic       first;
  logic [3:0] idx;

  assign irq_any = |(irq_pend_i & irq_en_i);
  assign first   = cpu_clk_en_o && !en_prev_q;
  assign idx     = first ? 4'd0 : cnt_q;

  // cycles since the clock enable came back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev_q <= 1'b1;
      cnt_q     <= 4'd0;
    end else begin
      en_prev_q <= cpu_clk_en_o;
      if (first)              cnt_q <= 4'd1;
      else if (cnt_q != 4'hF) cnt_q <= cnt_q + 4'd1;
    end
  end

  p_rst_vals_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (cpu_clk_en_o && !wdt_clr_o && !resume_o && !vec_sel_o));

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && pwrsav_req_i) |=> (!cpu_clk_en_o && wdt_clr_o));

  p_clr_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o);

  p_irq_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && irq_any) |=> (cpu_clk_en_o && vec_sel_o));

  p_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !irq_any && !wdt_timeout_i) |=> !cpu_clk_en_o);

  p_wdt_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !irq_any && wdt_timeout_i) |=> (cpu_clk_en_o && !vec_sel_o));

  p_resume_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (idx == 4'(WAKE_LAT - 1)));

  p_resume_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> (!resume_o && cpu_clk_en_o));

  p_vec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN) |=> $stable(vec_sel_o));

  p_held_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && pwrsav_req_i && irq_any) |=> ##1 (cpu_clk_en_o && vec_sel_o));

  p_ignore_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && pwrsav_req_i && !irq_any && !wdt_timeout_i) |=> !wdt_clr_o);

  p_run_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !pwrsav_req_i) |=> (cpu_clk_en_o && !wdt_clr_o && !resume_o));
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .WAKE_LAT (WAKE_LAT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwrsav_req_i  (pwrsav_req_i),
  .irq_pend_i    (irq_pend_i),
  .irq_en_i      (irq_en_i),
  .wdt_timeout_i (wdt_timeout_i),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .wdt_clr_o     (wdt_clr_o),
  .resume_o      (resume_o),
  .vec_sel_o     (vec_sel_o),
  .state_i       (state)
);

// File: tb/idle_pwr_ctrl_tb.sv
module idle_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 8;
  localparam int WAKE_LAT   = 3;
  localparam int NV         = 6;
  // {pend[7:0], en[7:0], wdt, expect_wake, expect_vec}
  localparam logic [18:0] VEC_TBL [NV] = '{
    {8'h01, 8'h01, 1'b0, 1'b1, 1'b1},
    {8'h80, 8'hFF, 1'b0, 1'b1, 1'b1},
    {8'h0F, 8'hF0, 1'b0, 1'b0, 1'b0},
    {8'h00, 8'hFF, 1'b1, 1'b1, 1'b0},
    {8'h10, 8'h10, 1'b1, 1'b1, 1'b1},
    {8'h3C, 8'h00, 1'b1, 1'b1, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst_ni;
  logic               pwrsav;
  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] en;
  logic               wdt;
  logic               clk_en, wdt_clr, resume, vec;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_pwr_ctrl #(.NUM_IRQ(NUM_IRQ), .WAKE_LAT(WAKE_LAT)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pwrsav_req_i  (pwrsav),
    .irq_pend_i    (pend),
    .irq_en_i      (en),
    .wdt_timeout_i (wdt),
    .cpu_clk_en_o  (clk_en),
    .wdt_clr_o     (wdt_clr),
    .resume_o      (resume),
    .vec_sel_o     (vec)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic enter_idle;
    pwrsav = 1'b1;
    step;
    pwrsav = 1'b0;
    chk("R2", "clk_en in entry cycle", clk_en, 0);
    chk("R3", "wdt_clr in entry cycle", wdt_clr, 1);
    step;
    chk("R2", "clk_en in idle", clk_en, 0);
    chk("R3", "wdt_clr after entry", wdt_clr, 0);
  endtask

  // call right after the edge that ends the wake-event cycle
  task automatic finish_wake(input logic exp_vec, input string req);
    int n;
    pend = '0; en = '0; wdt = 1'b0;
    chk("R6", "clk_en after wake", clk_en, 1);
    chk(req, "vec_sel after wake", vec, exp_vec);
    n = 1;
    while (!resume && n < 10) begin
      step;
      n++;
    end
    chk("R6", "resume latency", n, WAKE_LAT);
    step;
    chk("R6", "resume single cycle", resume, 0);
    chk("R6", "clk_en after resume", clk_en, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pwrsav = 1'b0; pend = '0; en = '0; wdt = 1'b0;
    #2;
    chk("R1", "clk_en in reset", clk_en, 1);
    chk("R1", "wdt_clr in reset", wdt_clr, 0);
    chk("R1", "resume in reset", resume, 0);
    chk("R1", "vec in reset", vec, 0);
    step; step;
    rst_ni = 1'b1;
    step;

    // table walk
    for (int i = 0; i < NV; i++) begin
      enter_idle();
      pend = VEC_TBL[i][18:11];
      en   = VEC_TBL[i][10:3];
      wdt  = VEC_TBL[i][2];
      step;
      if (VEC_TBL[i][1]) begin
        finish_wake(VEC_TBL[i][0], VEC_TBL[i][2] && !VEC_TBL[i][0] ? "R5" : "R7");
      end else begin
        for (int k = 0; k < 3; k++) begin
          chk("R4", "masked irq keeps idle", clk_en, 0);
          chk("R4", "masked irq no resume", resume, 0);
          step;
        end
        pend = '0; en = '0; wdt = 1'b1;
        step;
        finish_wake(1'b0, "R5");
      end
      step;
    end

    // R10: wake sources in run state do nothing
    pend = '1; en = '1; wdt = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step;
      chk("R10", "clk_en in run", clk_en, 1);
      chk("R10", "wdt_clr in run", wdt_clr, 0);
      chk("R10", "resume in run", resume, 0);
    end
    pend = '0; en = '0; wdt = 1'b0;
    step;

    // R8: interrupt coincident with the request
    pwrsav = 1'b1; pend = 8'h04; en = 8'h04;
    step;
    pwrsav = 1'b0; pend = '0; en = '0;
    chk("R8", "entry completes clk_en", clk_en, 0);
    chk("R8", "entry completes wdt_clr", wdt_clr, 1);
    step;
    finish_wake(1'b1, "R8");
    step;

    // R8: interrupt arriving during the entry cycle
    pwrsav = 1'b1;
    step;
    pwrsav = 1'b0; pend = 8'h40; en = 8'hC0;
    chk("R8", "entry cycle clk_en", clk_en, 0);
    step;
    finish_wake(1'b1, "R8");

    // R7: vec held in run
    step; step;
    chk("R7", "vec held in run", vec, 1);

    // R9: request held through entry and idle
    pwrsav = 1'b1;
    step;
    chk("R9", "wdt_clr entry", wdt_clr, 1);
    for (int k = 0; k < 4; k++) begin
      step;
      chk("R9", "no repeat wdt_clr", wdt_clr, 0);
      chk("R9", "stays idle", clk_en, 0);
    end
    pwrsav = 1'b0; wdt = 1'b1;
    step;
    wdt = 1'b0;
    // R9: request during wake phase ignored
    pwrsav = 1'b1;
    chk("R6", "clk_en after wdt wake", clk_en, 1);
    for (int k = 0; k < 10 && !resume; k++) step;
    pwrsav = 1'b0;
    chk("R6", "resume seen", resume, 1);
    chk("R7", "vec after wdt wake", vec, 0);
    step;
    chk("R9", "no entry from wake request", clk_en, 1);
    chk("R9", "no wdt_clr from wake request", wdt_clr, 0);

    // R1: asynchronous reset while idle
    pwrsav = 1'b1; pend = 8'h01; en = 8'h01;
    step;
    pwrsav = 1'b0; pend = '0; en = '0;
    step;
    finish_wake(1'b1, "R7");
    enter_idle();
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "async clk_en", clk_en, 1);
    chk("R1", "async vec clear", vec, 0);
    chk("R1", "async wdt_clr", wdt_clr, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step;
    chk("R1", "run after reset", clk_en, 1);
    chk("R1", "no resume after reset", resume, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule